// File: doc/BRIEF.md
# SPI Transmit/Receive Byte FIFO Pair with Level Interrupts

This block sits between the register bus of an SPI controller and its serial shift engine. It holds two byte queues. The bus pushes bytes into the transmit queue, and the shift engine pops them. The shift engine pushes received bytes into the receive queue, and the bus pops them. A status word reports the fill count of each queue at fixed bit positions, so software can size its refills and drains.

Three event flags are kept in a pending register that software clears by writing ones:

- the receive queue has reached three quarters full;
- the transmit queue has fallen to one quarter full or less;
- the shift engine has finished a transfer.

The two level flags are re-armed by their condition on every cycle. Software can therefore drain or refill first and clear afterwards, and it will not miss a level that still holds. A per-flag enable register gates the pending flags onto a single interrupt line. A control write can empty either queue on its own.

Top module: `spi_fifo_pair`

## Requirements
- R1: Each queue holds DEPTH bytes (64 by default) and returns them in first-in first-out order. Reset empties both queues and clears every pending flag and enable.
- R2: The level word carries the receive count in bits 6:0 and the transmit count in bits 22:16. All other bits of the level word read zero.
- R3: A push to a full queue is ignored. The count stays at DEPTH and no stored byte changes.
- R4: A pop from an empty queue is ignored. The count stays at zero, and the read data reads 0x00.
- R5: A control write with bit 8 set empties the transmit queue, and a control write with bit 9 set empties the receive queue. A control write without a given bit leaves that queue untouched.
- R6: Pending bit 4 sets on the clock edge after the edge on which the receive count reached 48 (DEPTH*3/4) or more.
- R7: Pending bit 12 sets on the clock edge after the transmit count is 16 (DEPTH/4) or fewer.
- R8: Pending bit 16 sets on the edge after a one-cycle transfer-done pulse. It then stays set until software clears it.
- R9: A status write clears exactly the pending bits written as 1, unless that bit's condition still holds. Writing all ones clears every pending flag whose condition is false.
- R10: A level flag whose condition still holds on the edge of its clear write stays set.
- R11: The enable register keeps only bits 4, 12 and 16, and all other bits read zero. The interrupt output is high exactly when some pending bit has its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_tx_push | input | 1 | Bus writes one byte into the transmit queue |
| bus_tx_data | input | 8 | Byte to push into the transmit queue |
| bus_rx_pop | input | 1 | Bus takes one byte from the receive queue |
| bus_rx_data | output | 8 | Head of the receive queue, 0 when empty |
| eng_tx_pop | input | 1 | Shift engine takes one byte from the transmit queue |
| eng_tx_data | output | 8 | Head of the transmit queue, 0 when empty |
| eng_rx_push | input | 1 | Shift engine stores one received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_xfer_done | input | 1 | One-cycle pulse when a transfer ends |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 32 | Control word: bit 8 empties transmit, bit 9 empties receive |
| ien_we | input | 1 | Enable register write strobe |
| ien_wdata | input | 32 | Enable register write data |
| ien_q | output | 32 | Enable register contents |
| sts_we | input | 1 | Status write strobe (write one to clear) |
| sts_wdata | input | 32 | Bits to clear in the pending register |
| sts_q | output | 32 | Pending flags at bits 4, 12, 16 |
| fifo_level | output | 32 | Receive count at 6:0, transmit count at 22:16 |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default DEPTH of 64. This places the thresholds at 48 and 16 and makes a full queue reachable in 64 pushes. With these values the bench can walk both queues to the full boundary and try an extra push there. It can also cross each threshold one byte at a time, checking the one-cycle lag from count to flag. Clear writes are then issued both while a level still holds and after it has lapsed, which shows the re-arm behaviour.

// File: rtl/spi_fifo_pkg.sv
// Shared constants for the SPI FIFO pair: field positions of the status,
// enable, control and level words, and the flag index to bit mapping.
package spi_fifo_pkg;
    localparam int NUM_FLAGS      = 3;
    localparam int FLAG_RX_HI     = 4;
    localparam int FLAG_TX_LO     = 12;
    localparam int FLAG_DONE      = 16;
    localparam int RX_CNT_LSB     = 0;
    localparam int TX_CNT_LSB     = 16;
    localparam int CNT_FIELD_W    = 7;
    localparam int CTL_TX_RST_BIT = 8;
    localparam int CTL_RX_RST_BIT = 9;
    localparam logic [31:0] FLAG_MASK = (32'd1 << FLAG_RX_HI) | (32'd1 << FLAG_TX_LO) | (32'd1 << FLAG_DONE);
    localparam logic [31:0] CTL_MASK  = (32'd1 << CTL_TX_RST_BIT) | (32'd1 << CTL_RX_RST_BIT);

    // Bit position in the status/enable words of flag index idx.
    function automatic int flag_pos(input int idx);
        case (idx)
            0:       return FLAG_RX_HI;
            1:       return FLAG_TX_LO;
            default: return FLAG_DONE;
        endcase
    endfunction
endpackage

// File: rtl/spi_byte_queue.sv
// Byte queue with a flush input, drop-on-full push and drop-on-empty pop.
// Assumes DEPTH is a power of two. Read data is the head byte, or zero when empty.
module spi_byte_queue #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, empty, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = empty ? '0 : mem[rd_ptr];

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy tracking, flush has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // R3
    full_push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush && full) |=> (count == CW'(DEPTH)))
        else $error("push to full queue changed count");
    // R4
    empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |-> (rdata == '0))
        else $error("empty queue returned non-zero data");
    // R4
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush && empty) |=> (count == '0))
        else $error("pop from empty queue changed count");
    // R5
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0))
        else $error("flush did not empty queue");
endmodule

// File: rtl/spi_flag_status.sv
// Pending flags (write one to clear, re-armed by their level condition each
// cycle), the enable register and the combined interrupt line.
// Assumes counts are CW bits wide and thresholds fit in that width.
module spi_flag_status
    import spi_fifo_pkg::*;
#(
    parameter int CW    = 7,
    parameter int RX_HI = 48,
    parameter int TX_LO = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic          xfer_done,
    input  logic          clr_we,
    input  logic [31:0]   clr_data,
    input  logic          en_we,
    input  logic [31:0]   en_data,
    output logic [31:0]   status,
    output logic [31:0]   enable,
    output logic          irq
);
    logic [NUM_FLAGS-1:0] pend, en, cond;
    logic                 unused_bits;

    assign cond[0] = (rx_count >= CW'(RX_HI));
    assign cond[1] = (tx_count <= CW'(TX_LO));
    assign cond[2] = xfer_done;
    assign unused_bits = ^(clr_data & ~FLAG_MASK) ^ ^(en_data & ~FLAG_MASK);

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        localparam int P = flag_pos(i);
        // Pending bit: clear on written one, set again while its condition holds.
        always_ff @(posedge clk) begin
            if (!rst_n) pend[i] <= 1'b0;
            else        pend[i] <= (pend[i] & ~(clr_we & clr_data[P])) | cond[i];
        end
        // Enable bit: loaded from its field on an enable write.
        always_ff @(posedge clk) begin
            if (!rst_n)     en[i] <= 1'b0;
            else if (en_we) en[i] <= en_data[P];
        end

        // R9
        w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_data[P] && !cond[i]) |=> !pend[i])
            else $error("written-one flag did not clear");
        // R10
        rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cond[i] |=> pend[i])
            else $error("flag missing while condition held");
        // R8
        sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[i] && !(clr_we && clr_data[P])) |=> pend[i])
            else $error("flag dropped without a clear");
    end

    // Spread internal flag vectors to their word positions.
    always_comb begin
        status = '0;
        enable = '0;
        for (int k = 0; k < NUM_FLAGS; k++) begin
            status[flag_pos(k)] = pend[k];
            enable[flag_pos(k)] = en[k];
        end
    end

    assign irq = |(pend & en);
endmodule

// File: rtl/spi_fifo_pair.sv
// SPI FIFO pair: transmit queue (bus pushes, engine pops), receive queue
// (engine pushes, bus pops), level word, pending flags and interrupt.
// Assumes DEPTH is a power of two no larger than 64 so counts fit 7-bit fields.
module spi_fifo_pair
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_tx_push,
    input  logic [7:0]  bus_tx_data,
    input  logic        bus_rx_pop,
    output logic [7:0]  bus_rx_data,
    input  logic        eng_tx_pop,
    output logic [7:0]  eng_tx_data,
    input  logic        eng_rx_push,
    input  logic [7:0]  eng_rx_data,
    input  logic        eng_xfer_done,
    input  logic        ctl_we,
    input  logic [31:0] ctl_wdata,
    input  logic        ien_we,
    input  logic [31:0] ien_wdata,
    output logic [31:0] ien_q,
    input  logic        sts_we,
    input  logic [31:0] sts_wdata,
    output logic [31:0] sts_q,
    output logic [31:0] fifo_level,
    output logic        irq
);
    localparam int CW    = $clog2(DEPTH) + 1;
    localparam int RX_HI = (DEPTH * 3) / 4;
    localparam int TX_LO = DEPTH / 4;

    logic [CW-1:0] tx_count, rx_count;
    logic          tx_flush, rx_flush, ctl_unused;

    assign tx_flush   = ctl_we && ctl_wdata[CTL_TX_RST_BIT];
    assign rx_flush   = ctl_we && ctl_wdata[CTL_RX_RST_BIT];
    assign ctl_unused = ^(ctl_wdata & ~CTL_MASK);

    spi_byte_queue #(.DEPTH(DEPTH), .W(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(bus_tx_push), .wdata(bus_tx_data),
        .pop(eng_tx_pop), .rdata(eng_tx_data), .count(tx_count)
    );

    spi_byte_queue #(.DEPTH(DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(eng_rx_push), .wdata(eng_rx_data),
        .pop(bus_rx_pop), .rdata(bus_rx_data), .count(rx_count)
    );

    spi_flag_status #(.CW(CW), .RX_HI(RX_HI), .TX_LO(TX_LO)) u_flags (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
        .xfer_done(eng_xfer_done), .clr_we(sts_we), .clr_data(sts_wdata),
        .en_we(ien_we), .en_data(ien_wdata), .status(sts_q), .enable(ien_q),
        .irq(irq)
    );

    // Place both counts in their fixed fields of the level word.
    always_comb begin
        fifo_level = '0;
        fifo_level[RX_CNT_LSB +: CNT_FIELD_W] = CNT_FIELD_W'(rx_count);
        fifo_level[TX_CNT_LSB +: CNT_FIELD_W] = CNT_FIELD_W'(tx_count);
    end

    // R2
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level[6:0] <= 7'(DEPTH)) && (fifo_level[22:16] <= 7'(DEPTH)))
        else $error("queue count beyond depth");
    // R11
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq)
        else $error("interrupt with all enables off");
endmodule

// File: tb/test_spi_fifo_pair.sv
module test_spi_fifo_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_tx_push = 0, bus_rx_pop = 0, eng_tx_pop = 0, eng_rx_push = 0;
    logic        eng_xfer_done = 0, ctl_we = 0, ien_we = 0, sts_we = 0;
    logic [7:0]  bus_tx_data = 0, eng_rx_data = 0, bus_rx_data, eng_tx_data;
    logic [31:0] ctl_wdata = 0, ien_wdata = 0, sts_wdata = 0, ien_q, sts_q, fifo_level;
    logic        irq;
    int          checks = 0, fails = 0;

    always #10 clk = ~clk;

    spi_fifo_pair i_spi_fifo_pair (
        .clk(clk), .rst_n(rst_n),
        .bus_tx_push(bus_tx_push), .bus_tx_data(bus_tx_data),
        .bus_rx_pop(bus_rx_pop), .bus_rx_data(bus_rx_data),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .eng_xfer_done(eng_xfer_done), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ien_we(ien_we), .ien_wdata(ien_wdata), .ien_q(ien_q),
        .sts_we(sts_we), .sts_wdata(sts_wdata), .sts_q(sts_q),
        .fifo_level(fifo_level), .irq(irq)
    );

    // {kind[1:0], data[7:0], expected count[6:0]}
    // kind 0: engine pushes rx, 1: bus pops rx, 2: bus pushes tx, 3: engine pops tx
    localparam logic [16:0] VEC [12] = '{
        {2'd0, 8'hA1, 7'd1}, {2'd0, 8'hB2, 7'd2}, {2'd2, 8'h11, 7'd1},
        {2'd1, 8'hA1, 7'd1}, {2'd2, 8'h22, 7'd2}, {2'd0, 8'hC3, 7'd2},
        {2'd3, 8'h11, 7'd1}, {2'd1, 8'hB2, 7'd1}, {2'd1, 8'hC3, 7'd0},
        {2'd3, 8'h22, 7'd0}, {2'd1, 8'h00, 7'd0}, {2'd3, 8'h00, 7'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply driven strobes on one rising edge, release them, return at the falling edge.
    task automatic step();
        @(posedge clk);
        #1;
        bus_tx_push = 0; bus_rx_pop = 0; eng_tx_pop = 0; eng_rx_push = 0;
        eng_xfer_done = 0; ctl_we = 0; ien_we = 0; sts_we = 0;
        @(negedge clk);
    endtask

    task automatic clear_flags(input logic [31:0] bits);
        sts_we = 1; sts_wdata = bits; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(); step();
        // R1 reset state
        chk("R1 reset pending", sts_q, 32'h0);
        chk("R2 reset level", fifo_level, 32'h0);
        chk("R11 reset irq", {31'b0, irq}, 32'h0);
        rst_n = 1;
        step(); step();
        chk("R7 empty tx raises flag", {31'b0, sts_q[12]}, 32'h1);
        chk("R6 rx flag idle", {31'b0, sts_q[4]}, 32'h0);

        // Table walk: ordering, counts, empty pops
        for (int n = 0; n < 12; n++) begin
            logic [1:0] kind;
            logic [7:0] d;
            logic [6:0] c;
            kind = VEC[n][16:15]; d = VEC[n][14:7]; c = VEC[n][6:0];
            case (kind)
                2'd0: begin eng_rx_push = 1; eng_rx_data = d; end
                2'd1: begin chk(n >= 10 ? "R4 rx data" : "R1 rx data", {24'b0, bus_rx_data}, {24'b0, d}); bus_rx_pop = 1; end
                2'd2: begin bus_tx_push = 1; bus_tx_data = d; end
                default: begin chk(n >= 10 ? "R4 tx data" : "R1 tx data", {24'b0, eng_tx_data}, {24'b0, d}); eng_tx_pop = 1; end
            endcase
            step();
            if (kind < 2) chk(n >= 10 ? "R4 rx count" : "R2 rx count", {25'b0, fifo_level[6:0]}, {25'b0, c});
            else          chk(n >= 10 ? "R4 tx count" : "R2 tx count", {25'b0, fifo_level[22:16]}, {25'b0, c});
        end
        chk("R2 spare bits zero", fifo_level & ~32'h007F_007F, 32'h0);

        // Transmit threshold and full boundary
        for (int k = 0; k < 16; k++) begin bus_tx_push = 1; bus_tx_data = 8'(k); step(); end
        step();
        chk("R7 tx at 16", {31'b0, sts_q[12]}, 32'h1);
        clear_flags(32'h0000_1000);
        chk("R10 tx clear while level holds", {31'b0, sts_q[12]}, 32'h1);
        bus_tx_push = 1; bus_tx_data = 8'd16; step();
        clear_flags(32'h0000_1000);
        chk("R9 tx clear at 17", {31'b0, sts_q[12]}, 32'h0);
        for (int k = 17; k < 64; k++) begin bus_tx_push = 1; bus_tx_data = 8'(k); step(); end
        chk("R2 tx count full", {25'b0, fifo_level[22:16]}, 32'd64);
        bus_tx_push = 1; bus_tx_data = 8'hEE; step();
        chk("R3 push to full tx", {25'b0, fifo_level[22:16]}, 32'd64);
        for (int k = 0; k < 47; k++) begin
            chk("R1 tx order", {24'b0, eng_tx_data}, 32'(k));
            eng_tx_pop = 1; step();
        end
        step();
        chk("R7 tx at 17 no flag", {31'b0, sts_q[12]}, 32'h0);
        eng_tx_pop = 1; step();
        chk("R7 flag lags count", {31'b0, sts_q[12]}, 32'h0);
        step();
        chk("R7 tx at 16 sets", {31'b0, sts_q[12]}, 32'h1);
        chk("R3 last byte intact", {24'b0, eng_tx_data}, 32'd48);
        ctl_we = 1; ctl_wdata = 32'h0000_0100; step();
        chk("R5 tx flush", {25'b0, fifo_level[22:16]}, 32'd0);

        // Receive threshold, enables, interrupt
        for (int k = 0; k < 47; k++) begin eng_rx_push = 1; eng_rx_data = 8'(8'h80 + k); step(); end
        step();
        chk("R6 rx at 47 no flag", {31'b0, sts_q[4]}, 32'h0);
        eng_rx_push = 1; eng_rx_data = 8'hAF; step();
        chk("R6 flag lags count", {31'b0, sts_q[4]}, 32'h0);
        step();
        chk("R6 rx at 48 sets", {31'b0, sts_q[4]}, 32'h1);
        ien_we = 1; ien_wdata = 32'hFFFF_EFFF; step();
        chk("R11 enable masked", ien_q, 32'h0001_0010);
        chk("R11 irq from rx flag", {31'b0, irq}, 32'h1);
        clear_flags(32'h0000_0010);
        chk("R10 rx clear while level holds", {31'b0, sts_q[4]}, 32'h1);
        chk("R1 rx head", {24'b0, bus_rx_data}, 32'h80);
        bus_rx_pop = 1; step();
        clear_flags(32'h0000_0010);
        chk("R9 rx clear at 47", {31'b0, sts_q[4]}, 32'h0);
        chk("R11 irq drops", {31'b0, irq}, 32'h0);
        for (int k = 0; k < 17; k++) begin eng_rx_push = 1; eng_rx_data = 8'h55; step(); end
        chk("R2 rx count full", {25'b0, fifo_level[6:0]}, 32'd64);
        eng_rx_push = 1; eng_rx_data = 8'h66; step();
        chk("R3 push to full rx", {25'b0, fifo_level[6:0]}, 32'd64);
        ctl_we = 1; ctl_wdata = 32'hFFFF_FDFF; step();
        chk("R5 rx kept without bit 9", {25'b0, fifo_level[6:0]}, 32'd64);
        ctl_we = 1; ctl_wdata = 32'h0000_0200; step();
        chk("R5 rx flush", {25'b0, fifo_level[6:0]}, 32'd0);
        chk("R4 rx empty data", {24'b0, bus_rx_data}, 32'h0);

        // Transfer done and full clear
        eng_xfer_done = 1; step();
        chk("R8 done sets", {31'b0, sts_q[16]}, 32'h1);
        chk("R11 irq from done", {31'b0, irq}, 32'h1);
        step(); step();
        chk("R8 done held", {31'b0, sts_q[16]}, 32'h1);
        clear_flags(32'hFFFE_FFFF);
        chk("R9 zero bit not cleared", {31'b0, sts_q[16]}, 32'h1);
        clear_flags(32'hFFFF_FFFF);
        chk("R9 all ones clear", sts_q, 32'h0000_1000);
        chk("R11 irq after clear", {31'b0, irq}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule